// File: doc/BRIEF.md
# Configurable Coefficient Matrix Multiplier

This block weighs three signed data samples per clock against a bank of nine signed coefficients arranged as three rows of three. The bank is written one row per clock: a 2-bit row-select code either holds every coefficient or picks the row that takes the three coefficient inputs at the next rising edge.

A 2-bit mode word sets what the shared multipliers compute. In matrix mode each coefficient row forms a dot product with the current sample triplet, which gives three 12-bit results per clock. In filter mode the triplets pass through a three-deep history, so nine samples are held. Each coefficient row weighs one age of that history. The sum is scaled and added to a 16-bit cascade input, and the result leaves on a 16-bit cascade output. Several blocks can therefore be chained into a longer filter.

Both remaining mode codes act exactly like filter mode. A change of mode flushes the pipeline and the sample history. A valid flag shows when the pipeline holds only data entered under the current mode.

Top module: `coef_matrix_engine`

## Requirements
- R1: A synchronous active-high reset clears all nine coefficients, the sample history, the pipeline and the outputs, and selects matrix mode. While the mode word stays 00, samples entered after reset are therefore weighted by zero coefficients.
- R2: The row-select code decides what is written at the next rising edge: 00 keeps all coefficients, 01 writes row 1, 10 writes row 2 and 11 writes row 3. In each case the three coefficient inputs go to columns A, B and C of that row. A row written in a given cycle already applies to the sample triplet presented in that same cycle.
- R3: In mode 00 (matrix), row r of the output is formed as follows. The sum of coefficient(r,A)·A + coefficient(r,B)·B + coefficient(r,C)·C is multiplied by 2^-9, then rounded by adding one half and taking the floor. Row 1 drives outX, row 2 drives outY and row 3 drives outZ, and casOut reads zero.
- R4: In matrix mode each rounded row result saturates to the 12-bit range -2048..2047.
- R5: A triplet presented in cycle n shows up on the outputs just after the third rising edge that follows it.
- R6: In mode 01 (filter), row 1 weighs the newest triplet, row 2 the triplet before it and row 3 the one before that, column by column. casOut equals the nine-term sum times 2^-9, rounded as in R3, plus the casIn value presented with the newest triplet. outX, outY and outZ read zero in this mode.
- R7: In filter mode the cascade result saturates to the 16-bit range -32768..32767.
- R8: Mode codes 10 and 11 give results identical to mode 01.
- R9: The first rising edge at which the mode word differs from the active mode is a flush edge. At that edge the new mode takes effect, the sample presented is discarded, the history and the pipeline are cleared, and all four result outputs read zero just after it.
- R10: After reset or a flush edge, outValid stays low and then goes high. It rises after the third further edge in matrix mode and after the fifth in the other modes, then stays high until the next flush or reset. While the history refills, the older ages read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | Operation mode word |
| coefWe | input | 2 | Coefficient row select; 00 holds |
| coefA | input | 10 | Coefficient for column A, signed |
| coefB | input | 10 | Coefficient for column B, signed |
| coefC | input | 10 | Coefficient for column C, signed |
| dinA | input | 12 | Sample A, signed |
| dinB | input | 12 | Sample B, signed |
| dinC | input | 12 | Sample C, signed |
| casIn | input | 16 | Cascade input added in filter modes, signed |
| outX | output | 12 | Matrix row 1 result, signed |
| outY | output | 12 | Matrix row 2 result, signed |
| outZ | output | 12 | Matrix row 3 result, signed |
| casOut | output | 16 | Cascade result in filter modes, signed |
| outValid | output | 1 | Outputs come from post-flush data only |

## Verification
The bench builds the block with its default widths: 12-bit samples, 10-bit coefficients, 9 fractional coefficient bits and a 16-bit cascade. With these widths, full-scale samples against full-scale coefficients carry both the row sums and the cascade sum past their limits, so both saturation clamps are hit at each sign. The same widths keep a flush at every mode transition inside a short run, which lets the bench exercise the refill window where history ages still read zero.

// File: rtl/cme_pkg.sv
package cme_pkg;

  // Coefficient bank geometry: rows of weights, columns of samples.
  localparam int NROW     = 3;
  localparam int NCOL     = 3;
  // Register stages from the sample inputs to the result outputs.
  localparam int PIPE_LAT = 3;

  typedef enum logic [1:0] {
    MODE_MATRIX = 2'b00,
    MODE_FIR    = 2'b01,
    MODE_ALT_A  = 2'b10,
    MODE_ALT_B  = 2'b11
  } cme_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic            flush;  // mode transition: clear history and pipeline
    logic            fir;    // active mode uses the history taps
    logic [NROW-1:0] rowWr;  // one-hot coefficient row write
  } cme_strobe_t;

endpackage

// File: rtl/cme_ctrl.sv
module cme_ctrl
  import cme_pkg::*;
#(
  parameter int LAT = PIPE_LAT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  logic [1:0]  coefWe,
  output cme_strobe_t strb,
  output logic        outValid
);

  // Matrix results need only the pipeline to refill; the filter needs
  // NROW-1 extra triplets of history on top of it.
  localparam int FILL_MAT = LAT;
  localparam int FILL_FIR = LAT + NROW - 1;
  localparam int CNT_W    = $clog2(FILL_FIR + 1);

  logic [1:0]       modeQ;
  logic             modeChange;
  logic             firMode;
  logic [CNT_W-1:0] fillCnt;
  logic [NROW-1:0]  rowSel;

  assign modeChange = (modeSel != modeQ);
  assign firMode    = (modeQ != MODE_MATRIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ   <= MODE_MATRIX;
      fillCnt <= '0;
    end else if (modeChange) begin
      modeQ   <= modeSel;
      fillCnt <= '0;
    end else if (fillCnt != CNT_W'(FILL_FIR)) begin
      fillCnt <= fillCnt + CNT_W'(1);
    end
  end

  // Row-select code k (1..NROW) writes row k-1; code 0 holds the bank.
  for (genvar r = 0; r < NROW; r++) begin : g_rowdec
    assign rowSel[r] = (coefWe == 2'(r + 1));
  end

  assign strb = '{flush: modeChange, fir: firMode, rowWr: rowSel};

  assign outValid = (fillCnt >= (firMode ? CNT_W'(FILL_FIR) : CNT_W'(FILL_MAT)));

  // R10: a flush edge always leaves the outputs flagged invalid.
  p_flush_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    strb.flush |=> !outValid);

  // R10: once valid, the flag holds until the next flush.
  p_valid_stays_r10: assert property (@(posedge clk) disable iff (rst)
    (outValid && !strb.flush) |=> outValid);

endmodule

// File: rtl/cme_datapath.sv
module cme_datapath
  import cme_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 10,
  parameter int FRAC = 9,
  parameter int CASW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cme_strobe_t            strb,
  input  logic signed [CW-1:0]   coefA,
  input  logic signed [CW-1:0]   coefB,
  input  logic signed [CW-1:0]   coefC,
  input  logic signed [DW-1:0]   dinA,
  input  logic signed [DW-1:0]   dinB,
  input  logic signed [DW-1:0]   dinC,
  input  logic signed [CASW-1:0] casIn,
  output logic signed [DW-1:0]   outX,
  output logic signed [DW-1:0]   outY,
  output logic signed [DW-1:0]   outZ,
  output logic signed [CASW-1:0] casOut
);

  // FRAC must be at least 1 for the half-LSB rounding constant.
  localparam int PW    = DW + CW;
  localparam int GROWW = PW + $clog2(NROW * NCOL);
  localparam int CASSH = CASW + FRAC;
  localparam int ACCW  = ((GROWW > CASSH) ? GROWW : CASSH) + 2;

  localparam logic signed [ACCW-1:0] HALF  = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] D_MAX = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] D_MIN = ~D_MAX;
  localparam logic signed [ACCW-1:0] C_MAX = (ACCW'(1) <<< (CASW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] C_MIN = ~C_MAX;

  function automatic logic signed [ACCW-1:0] roundShift(input logic signed [ACCW-1:0] v);
    return (v + HALF) >>> FRAC;
  endfunction

  function automatic logic signed [DW-1:0] satData(input logic signed [ACCW-1:0] v);
    if (v > D_MAX)      return D_MAX[DW-1:0];
    else if (v < D_MIN) return D_MIN[DW-1:0];
    else                return v[DW-1:0];
  endfunction

  function automatic logic signed [CASW-1:0] satCas(input logic signed [ACCW-1:0] v);
    if (v > C_MAX)      return C_MAX[CASW-1:0];
    else if (v < C_MIN) return C_MIN[CASW-1:0];
    else                return v[CASW-1:0];
  endfunction

  logic                   clr;
  logic signed [CW-1:0]   kIn    [NCOL];
  logic signed [DW-1:0]   dIn    [NCOL];
  logic signed [CW-1:0]   coef   [NROW][NCOL];
  logic signed [DW-1:0]   tap    [NROW][NCOL];
  logic signed [DW-1:0]   opnd   [NROW][NCOL];
  logic signed [PW-1:0]   prod   [NROW][NCOL];
  logic signed [CASW-1:0] casQ1, casQ2;
  logic signed [ACCW-1:0] rowSum [NROW];
  logic signed [ACCW-1:0] firSum;
  logic signed [DW-1:0]   rowSat [NROW];
  logic signed [DW-1:0]   rowOut [NROW];
  logic signed [CASW-1:0] casReg;

  assign clr = rst | strb.flush;

  assign kIn[0] = coefA;
  assign kIn[1] = coefB;
  assign kIn[2] = coefC;
  assign dIn[0] = dinA;
  assign dIn[1] = dinB;
  assign dIn[2] = dinC;

  // Coefficient bank: only reset clears it, a mode flush leaves it alone.
  always_ff @(posedge clk) begin
    for (int r = 0; r < NROW; r++) begin
      for (int j = 0; j < NCOL; j++) begin
        if (rst)                coef[r][j] <= '0;
        else if (strb.rowWr[r]) coef[r][j] <= kIn[j];
      end
    end
  end

  // Multiplier operand: the newest triplet in matrix mode, the history
  // age matching the row in filter mode.
  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar j = 0; j < NCOL; j++) begin : g_col
      assign opnd[r][j] = strb.fir ? tap[r][j] : tap[0][j];

      // R2: a row whose write strobe is low keeps its coefficients.
      p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !strb.rowWr[r] |=> $stable(coef[r][j]));
    end
  end

  // Stage 1: sample history and cascade capture. Stage 2: products.
  always_ff @(posedge clk) begin
    if (clr) begin
      casQ1 <= '0;
      casQ2 <= '0;
      for (int r = 0; r < NROW; r++) begin
        for (int j = 0; j < NCOL; j++) begin
          tap[r][j]  <= '0;
          prod[r][j] <= '0;
        end
      end
    end else begin
      casQ1 <= casIn;
      casQ2 <= casQ1;
      for (int j = 0; j < NCOL; j++) tap[0][j] <= dIn[j];
      for (int r = 1; r < NROW; r++) begin
        for (int j = 0; j < NCOL; j++) tap[r][j] <= tap[r-1][j];
      end
      for (int r = 0; r < NROW; r++) begin
        for (int j = 0; j < NCOL; j++) prod[r][j] <= PW'(opnd[r][j]) * PW'(coef[r][j]);
      end
    end
  end

  // Stage 3 arithmetic: full-precision row sums and the cascade total.
  always_comb begin
    firSum = ACCW'(casQ2) <<< FRAC;
    for (int r = 0; r < NROW; r++) begin
      rowSum[r] = '0;
      for (int j = 0; j < NCOL; j++) rowSum[r] = rowSum[r] + ACCW'(prod[r][j]);
      firSum = firSum + rowSum[r];
    end
  end

  for (genvar r = 0; r < NROW; r++) begin : g_sat
    assign rowSat[r] = satData(roundShift(rowSum[r]));
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int r = 0; r < NROW; r++) rowOut[r] <= '0;
      casReg <= '0;
    end else if (strb.fir) begin
      for (int r = 0; r < NROW; r++) rowOut[r] <= '0;
      casReg <= satCas(roundShift(firSum));
    end else begin
      for (int r = 0; r < NROW; r++) rowOut[r] <= rowSat[r];
      casReg <= '0;
    end
  end

  assign outX   = rowOut[0];
  assign outY   = rowOut[1];
  assign outZ   = rowOut[2];
  assign casOut = casReg;

  // R9: every result output reads zero right after a flush edge.
  p_flush_zero_r9: assert property (@(posedge clk) disable iff (rst)
    strb.flush |=> (outX == '0 && outY == '0 && outZ == '0 && casOut == '0));

  // R3: the cascade output stays silent in matrix mode.
  p_matrix_cas_r3: assert property (@(posedge clk) disable iff (rst)
    (!strb.fir && !strb.flush) |=> (casOut == '0));

  // R6: the matrix outputs stay silent in the filter modes.
  p_fir_rows_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.fir && !strb.flush) |=> (outX == '0 && outY == '0 && outZ == '0));

endmodule

// File: rtl/coef_matrix_engine.sv
module coef_matrix_engine
  import cme_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 9,
  parameter int CAS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              modeSel,
  input  logic [1:0]              coefWe,
  input  logic signed [COEF_W-1:0] coefA,
  input  logic signed [COEF_W-1:0] coefB,
  input  logic signed [COEF_W-1:0] coefC,
  input  logic signed [DATA_W-1:0] dinA,
  input  logic signed [DATA_W-1:0] dinB,
  input  logic signed [DATA_W-1:0] dinC,
  input  logic signed [CAS_W-1:0]  casIn,
  output logic signed [DATA_W-1:0] outX,
  output logic signed [DATA_W-1:0] outY,
  output logic signed [DATA_W-1:0] outZ,
  output logic signed [CAS_W-1:0]  casOut,
  output logic                    outValid
);

  cme_strobe_t strb;

  cme_ctrl #(
    .LAT (PIPE_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .coefWe   (coefWe),
    .strb     (strb),
    .outValid (outValid)
  );

  cme_datapath #(
    .DW   (DATA_W),
    .CW   (COEF_W),
    .FRAC (FRAC_W),
    .CASW (CAS_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .coefA  (coefA),
    .coefB  (coefB),
    .coefC  (coefC),
    .dinA   (dinA),
    .dinB   (dinB),
    .dinC   (dinC),
    .casIn  (casIn),
    .outX   (outX),
    .outY   (outY),
    .outZ   (outZ),
    .casOut (casOut)
  );

endmodule

// File: tb/sim_coef_matrix_engine.sv
module sim_coef_matrix_engine;

  localparam int DW   = 12;
  localparam int CW   = 10;
  localparam int FR   = 9;
  localparam int CASW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] modeSel, coefWe;
  logic signed [CW-1:0]   coefA, coefB, coefC;
  logic signed [DW-1:0]   dinA, dinB, dinC;
  logic signed [CASW-1:0] casIn;
  logic signed [DW-1:0]   outX, outY, outZ;
  logic signed [CASW-1:0] casOut;
  logic outValid;

  always #2 clk = ~clk;

  coef_matrix_engine #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(FR), .CAS_W(CASW)) u0 (
    .clk(clk), .rst(rst), .modeSel(modeSel), .coefWe(coefWe),
    .coefA(coefA), .coefB(coefB), .coefC(coefC),
    .dinA(dinA), .dinB(dinB), .dinC(dinC), .casIn(casIn),
    .outX(outX), .outY(outY), .outZ(outZ), .casOut(casOut), .outValid(outValid)
  );

  typedef struct {
    int    due;
    bit    v;
    int    x, y, z, c;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon;
  int   cyc = 0;
  int   nChk = 0, nBad = 0;
  bit   done = 1'b0;
  int   kM[3][3];
  int   hist[3][3];
  int   histN = 0;
  int   modeM = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rnd(input longint v);
    return (v + (longint'(1) <<< (FR - 1))) >>> FR;
  endfunction

  function automatic int sat(input longint v, input int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -hi - 1;
    if (v > hi) return int'(hi);
    if (v < lo) return int'(lo);
    return int'(v);
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic clearModel();
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 3; j++) hist[r][j] = 0;
    histN = 0;
  endtask

  // Drive one triplet (and optional row write) now; queue its expected result.
  task automatic apply(input int a, input int b, input int c, input int cs,
                       input int we, input int ka, input int kb, input int kc,
                       input string tag);
    exp_t e;
    dinA = DW'(a); dinB = DW'(b); dinC = DW'(c); casIn = CASW'(cs);
    coefWe = 2'(we); coefA = CW'(ka); coefB = CW'(kb); coefC = CW'(kc);
    if (we != 0) begin
      kM[we-1][0] = ka; kM[we-1][1] = kb; kM[we-1][2] = kc;
    end
    for (int r = 2; r > 0; r--) hist[r] = hist[r-1];
    hist[0] = '{a, b, c};
    histN++;
    e.due = cyc + 3;
    e.tag = tag;
    if (modeM == 0) begin
      longint s[3];
      for (int r = 0; r < 3; r++) begin
        s[r] = 0;
        for (int j = 0; j < 3; j++) s[r] += longint'(kM[r][j]) * hist[0][j];
      end
      e.x = sat(rnd(s[0]), DW); e.y = sat(rnd(s[1]), DW); e.z = sat(rnd(s[2]), DW);
      e.c = 0;
      e.v = 1'b1;
    end else begin
      longint acc = longint'(cs) <<< FR;
      for (int r = 0; r < 3; r++)
        for (int j = 0; j < 3; j++) acc += longint'(kM[r][j]) * hist[r][j];
      e.x = 0; e.y = 0; e.z = 0;
      e.c = sat(rnd(acc), CASW);
      e.v = (histN >= 3);
      if (!e.v) e.tag = "R10";
    end
    q.push_back(e);
  endtask

  task automatic drive(input int a, input int b, input int c, input int cs,
                       input int we, input int ka, input int kb, input int kc,
                       input string tag);
    @(negedge clk);
    apply(a, b, c, cs, we, ka, kb, kc, tag);
  endtask

  function automatic int rs(input int w);
    return int'($urandom_range(0, (1 << w) - 1)) - (1 << (w - 1));
  endfunction

  // Mode change: a flush edge with a throw-away sample, then a check of the cleared outputs.
  task automatic setMode(input int m);
    @(negedge clk);
    while (q.size() > 0 && q[$].due > cyc) void'(q.pop_back());
    modeSel = 2'(m);
    dinA = 12'sd777; dinB = -12'sd555; dinC = 12'sd333; casIn = 16'sd1234; coefWe = 2'b00;
    @(negedge clk);
    check(outX == 0 && outY == 0 && outZ == 0 && casOut == 0 && !outValid, "R9",
          $sformatf("after flush X=%0d Y=%0d Z=%0d cas=%0d v=%0b, expected all 0 v=0",
                    outX, outY, outZ, casOut, outValid));
    modeM = m;
    clearModel();
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R9");
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        mon = q.pop_front();
        check(mon.due == cyc && outValid == mon.v && int'(outX) == mon.x &&
              int'(outY) == mon.y && int'(outZ) == mon.z && int'(casOut) == mon.c,
              mon.tag,
              $sformatf("cyc %0d actual X=%0d Y=%0d Z=%0d cas=%0d v=%0b expected X=%0d Y=%0d Z=%0d cas=%0d v=%0b",
                        cyc, outX, outY, outZ, casOut, outValid,
                        mon.x, mon.y, mon.z, mon.c, mon.v));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL R5: watchdog expired, actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; modeSel = 2'b00; coefWe = 2'b00;
    coefA = '0; coefB = '0; coefC = '0; dinA = '0; dinB = '0; dinC = '0; casIn = '0;
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 3; j++) kM[r][j] = 0;
    clearModel();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(outX == 0 && outY == 0 && outZ == 0 && casOut == 0 && !outValid, "R1",
          $sformatf("reset X=%0d Y=%0d Z=%0d cas=%0d v=%0b expected all 0 v=0",
                    outX, outY, outZ, casOut, outValid));
    apply(100, -200, 300, 0, 0, 0, 0, 0, "R1");

    // R2: row writes, each applied to the sample of the same cycle
    drive(1000, -700, 450, 0, 1, 256, -128, 64, "R2");
    drive(-1500, 900, 20, 0, 2, -300, 511, -512, "R2");
    drive(2047, -2048, 5, 0, 3, 17, -33, 400, "R2");
    // R3: matrix dot products over varied samples
    for (int i = 0; i < 20; i++) drive(rs(DW), rs(DW), rs(DW), rs(CASW), 0, 0, 0, 0, "R3");
    // R2: hold code ignores coefficient inputs
    for (int i = 0; i < 4; i++) drive(rs(DW), rs(DW), rs(DW), 0, 0, rs(CW), rs(CW), rs(CW), "R2");
    // R5: impulse followed by zeros lands exactly three edges later
    drive(1024, 0, 0, 0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R4: saturation both ways
    drive(0, 0, 0, 0, 1, 511, 511, 511, "R4");
    drive(0, 0, 0, 0, 2, -512, -512, -512, "R4");
    drive(0, 0, 0, 0, 3, 3, -2, 1, "R4");
    drive(2047, 2047, 2047, 0, 0, 0, 0, 0, "R4");
    drive(-2048, -2048, -2048, 0, 0, 0, 0, 0, "R4");
    drive(2047, -2048, 2047, 0, 0, 0, 0, 0, "R4");

    // R6 / R10: filter mode
    setMode(1);
    drive(500, -400, 300, 100, 1, 200, -150, 90, "R6");
    drive(-800, 700, 600, -2000, 2, -60, 310, 45, "R6");
    drive(1200, 30, -900, 5000, 3, 12, -250, 480, "R6");
    for (int i = 0; i < 16; i++) drive(rs(DW), rs(DW), rs(DW), rs(14), 0, 0, 0, 0, "R6");
    // R7: cascade saturation
    drive(0, 0, 0, 0, 1, 511, 511, 511, "R7");
    drive(0, 0, 0, 0, 2, 511, 511, 511, "R7");
    drive(0, 0, 0, 0, 3, 511, 511, 511, "R7");
    for (int i = 0; i < 4; i++) drive(2047, 2047, 2047, 30000, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) drive(-2048, -2048, -2048, -30000, 0, 0, 0, 0, "R7");

    // R8: the other two codes behave as the filter
    setMode(2);
    drive(0, 0, 0, 0, 1, -77, 140, 333, "R8");
    for (int i = 0; i < 10; i++) drive(rs(DW), rs(DW), rs(DW), rs(14), 0, 0, 0, 0, "R8");
    setMode(3);
    drive(0, 0, 0, 0, 2, 250, -19, -400, "R8");
    for (int i = 0; i < 10; i++) drive(rs(DW), rs(DW), rs(DW), rs(14), 0, 0, 0, 0, "R8");

    // R10: back to matrix, valid after three edges
    setMode(0);
    for (int i = 0; i < 8; i++) drive(rs(DW), rs(DW), rs(DW), 0, 0, 0, 0, 0, "R10");

    // R1: mid-run reset clears the coefficient bank
    @(negedge clk);
    rst = 1'b1;
    q.delete();
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 3; j++) kM[r][j] = 0;
    clearModel();
    modeM = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(outX == 0 && outY == 0 && outZ == 0 && casOut == 0 && !outValid, "R1",
          $sformatf("mid reset X=%0d Y=%0d Z=%0d cas=%0d v=%0b expected all 0 v=0",
                    outX, outY, outZ, casOut, outValid));
    apply(1500, -1500, 999, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) drive(rs(DW), rs(DW), rs(DW), 0, 0, 0, 0, 0, "R1");

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R5", $sformatf("pending items actual %0d expected 0", q.size()));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule